// File: doc/BRIEF.md
# Float-to-Signed-Integer Converter

This block turns an unpacked floating-point operand into a signed two's-complement integer. The operand arrives in an internal form: a class code, a sign, an unbiased exponent, a mantissa whose top bit is the explicit leading one, and a sticky bit that stands for any less significant bits already dropped upstream. The result is an integer `INT_W` bits wide, 32 by default and 64 when the parameter is set that way. Two flags come with it. One says that the conversion was invalid. The other says that nonzero fraction bits were discarded.

The conversion always truncates toward zero, whatever rounding mode the rest of the datapath uses. The saturation is asymmetric so that the most negative integer can still be produced. An operand that is too large, infinite or not a number gives a fixed saturated code and sets the invalid flag.

Each operand is presented for one cycle with `in_valid`. The integer and both flags are registered and appear one clock later with `out_valid`. They hold their values until the next valid operand.

Top module: `fp2i_conv`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The integer and flags change only in that cycle and hold otherwise. Synchronous reset clears all outputs to 0.
- R2: Class code 0 (zero) gives integer 0 with both flags low, whatever the sign, exponent and mantissa are.
- R3: For class code 1 (number) with 0 <= exponent < `INT_W`, the magnitude is floor(mant / 2^(`MANT_W`-1-exponent)). This means the mantissa's top bit has weight 2^exponent. The result is that magnitude, or its two's-complement negation when the sign is 1, provided R6 does not apply.
- R4: For an in-range number, the lost flag is 1 exactly when some discarded mantissa bit is 1 or the sticky bit is 1.
- R5: For a number with a negative exponent, the integer is 0 and the lost flag is 1.
- R6: A number whose magnitude is at least 2^(`INT_W`-1) plus the sign bit is invalid. This means +2^(`INT_W`-1) is rejected and -2^(`INT_W`-1) is returned exactly.
- R7: A number with exponent >= `INT_W` is invalid.
- R8: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and any code above 4 are invalid.
- R9: Every invalid result is 2^(`INT_W`-1)-1 plus the sign bit: 0x7FFFFFFF when the sign is positive and 0x80000000 when it is negative, at the default width. The lost flag is 0 whenever the invalid flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_class | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Mantissa; the top bit has weight 2^exponent |
| in_sticky | input | 1 | OR of bits dropped below the mantissa |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_int | output | INT_W | Signed integer result |
| out_invalid | output | 1 | Invalid conversion |
| out_lost | output | 1 | Nonzero fraction bits were discarded |

## Verification
The hardest cases to reach from the ports sit at the edge of the integer range. With exponent `INT_W`-1 and a mantissa of a lone leading one, the magnitude is exactly 2^(`INT_W`-1), so the sign alone decides between a valid most-negative value and an invalid result. A set mantissa bit just below the binary point has to show up as lost bits without changing the integer. The stimulus reaches these cases by sweeping every exponent from below zero to past the integer width. The sweep uses both signs, both sticky values, and mantissa patterns with a lone leading one, all ones, alternating bits and isolated low bits. Expected values come from integer division and remainder by powers of two.

// File: rtl/fp2i_pkg.sv
package fp2i_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fp_class_e;
endpackage

// File: rtl/fp2i_align.sv
// Moves the integer part of the mantissa down into the low INT_W bits
// and gathers everything shifted out into the lost-bits flag.
module fp2i_align #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 66,
  parameter int EXP_W  = 12
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  output logic [INT_W-1:0]  mag_o,
  output logic              lost_o,
  output logic              exp_big_o
);
  localparam int SH_W = $clog2(MANT_W);
  localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);

  logic signed [EXP_W-1:0] exp_s;
  logic [SH_W-1:0]         sh;
  logic [MANT_W-1:0]       low_mask;
  logic                    exp_neg;

  assign exp_s     = $signed(exp_i);
  assign exp_neg   = exp_s < 0;
  assign exp_big_o = !exp_neg && (exp_s >= EXP_LIM);
  assign sh        = SH_W'(MANT_W - 1) - SH_W'(exp_i);
  assign low_mask  = ~({MANT_W{1'b1}} << sh);

  always_comb begin
    if (exp_neg) begin
      mag_o  = '0;
      lost_o = (|mant_i) | sticky_i;
    end else if (exp_big_o) begin
      mag_o  = '0;
      lost_o = 1'b0;
    end else begin
      mag_o  = INT_W'(mant_i >> sh);
      lost_o = (|(mant_i & low_mask)) | sticky_i;
    end
  end
endmodule

// File: rtl/fp2i_range.sv
// Checks the magnitude against the asymmetric signed limit, applies the sign
// and supplies the saturation code.
module fp2i_range #(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0] mag_i,
  input  logic             sign_i,
  output logic             ovf_o,
  output logic [INT_W-1:0] signed_o,
  output logic [INT_W-1:0] sat_o
);
  localparam logic [INT_W:0] HALF = (INT_W+1)'(1) << (INT_W-1);
  localparam logic [INT_W-1:0] MAXPOS = {1'b0, {(INT_W-1){1'b1}}};

  logic [INT_W:0] limit;

  assign limit    = HALF + (INT_W+1)'(sign_i);
  assign ovf_o    = {1'b0, mag_i} >= limit;
  assign signed_o = sign_i ? (~mag_i + INT_W'(1)) : mag_i;
  assign sat_o    = MAXPOS + INT_W'(sign_i);
endmodule

// File: rtl/fp2i_conv.sv
module fp2i_conv
  import fp2i_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int MANT_W = 66,
  parameter int EXP_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_class,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  output logic              out_valid,
  output logic [INT_W-1:0]  out_int,
  output logic              out_invalid,
  output logic              out_lost
);
  logic [INT_W-1:0] mag, signed_val, sat_val, nxt_int;
  logic             lost, exp_big, ovf, nxt_inv, nxt_lost;

  fp2i_align #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
    .exp_i(in_exp), .mant_i(in_mant), .sticky_i(in_sticky),
    .mag_o(mag), .lost_o(lost), .exp_big_o(exp_big)
  );

  fp2i_range #(.INT_W(INT_W)) u_range (
    .mag_i(mag), .sign_i(in_sign), .ovf_o(ovf),
    .signed_o(signed_val), .sat_o(sat_val)
  );

  always_comb begin
    nxt_int  = '0;
    nxt_inv  = 1'b0;
    nxt_lost = 1'b0;
    case (in_class)
      CLS_ZERO: ;
      CLS_NUM: begin
        if (exp_big || ovf) begin
          nxt_inv = 1'b1;
          nxt_int = sat_val;
        end else begin
          nxt_int  = signed_val;
          nxt_lost = lost;
        end
      end
      default: begin
        nxt_inv = 1'b1;
        nxt_int = sat_val;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_invalid <= 1'b0;
      out_lost    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_int     <= nxt_int;
        out_invalid <= nxt_inv;
        out_lost    <= nxt_lost;
      end
    end
  end
endmodule

// File: rtl/fp2i_chk.sv
module fp2i_chk #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 66,
  parameter int EXP_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        in_class,
  input logic              in_sign,
  input logic [EXP_W-1:0]  in_exp,
  input logic [MANT_W-1:0] in_mant,
  input logic              in_sticky,
  input logic              out_valid,
  input logic [INT_W-1:0]  out_int,
  input logic              out_invalid,
  input logic              out_lost
);
  localparam logic [INT_W-1:0] SAT_P = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SAT_N = {1'b1, {(INT_W-1){1'b0}}};

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_HOLD_INT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_int) && $stable(out_invalid)); // R1
  AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class == 3'd0) |=> (out_int == '0 && !out_invalid && !out_lost)); // R2
  AST_NEG_EXP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class == 3'd1 && in_exp[EXP_W-1]) |=> (out_int == '0 && out_lost && !out_invalid)); // R5
  AST_NONNUM_INVALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class > 3'd1) |=> out_invalid); // R8
  AST_SAT_CODE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid) |-> (out_int == SAT_P || out_int == SAT_N)); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_invalid && out_lost)); // R9
endmodule

bind fp2i_conv fp2i_chk #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
  .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
  .out_valid(out_valid), .out_int(out_int), .out_invalid(out_invalid),
  .out_lost(out_lost)
);

// File: tb/tb_fp2i_conv.sv
module tb_fp2i_conv;
  localparam int INT_W = 32, MANT_W = 66, EXP_W = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_sign = 1'b0, in_sticky = 1'b0;
  logic [2:0] in_class = '0;
  logic [EXP_W-1:0] in_exp = '0;
  logic [MANT_W-1:0] in_mant = '0;
  logic out_valid, out_invalid, out_lost;
  logic [INT_W-1:0] out_int;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fp2i_conv #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) dut (.*);

  task automatic apply(input logic [2:0] cls, input logic sg, input int e,
                       input logic [MANT_W-1:0] m, input logic st);
    logic [127:0] m128, div, q, r;
    logic [31:0]  exp_int;
    logic         exp_inv, exp_lost;
    string        tag;
    m128 = 128'(m);
    exp_int = 0; exp_inv = 0; exp_lost = 0; tag = "R3";
    if (cls == 3'd0) tag = "R2";
    else if (cls != 3'd1) begin exp_inv = 1; tag = "R8"; end
    else if (e < 0) begin exp_lost = (m != 0) || st; tag = "R5"; end
    else if (e >= INT_W) begin exp_inv = 1; tag = "R7"; end
    else begin
      div = 128'd1 << (MANT_W - 1 - e);
      q = m128 / div;
      r = m128 % div;
      if (q >= 128'h8000_0000 + 128'(sg)) begin exp_inv = 1; tag = "R6"; end
      else begin
        exp_int = sg ? 32'(-q) : 32'(q);
        exp_lost = (r != 0) || st;
        if (exp_lost) tag = "R4";
      end
    end
    if (exp_inv) exp_int = sg ? 32'h8000_0000 : 32'h7FFF_FFFF; // R9
    @(negedge clk);
    in_valid = 1; in_class = cls; in_sign = sg; in_exp = EXP_W'(e);
    in_mant = m; in_sticky = st;
    @(negedge clk);
    in_valid = 0; in_class = 3'd1; in_exp = '0; in_mant = '1; in_sticky = 1;
    n_vec++;
    if (!out_valid || out_int !== exp_int || out_invalid !== exp_inv || out_lost !== exp_lost) begin
      n_bad++;
      $display("FAIL %s cls=%0d sg=%0b e=%0d: got v=%0b int=%h inv=%0b lost=%0b exp v=1 int=%h inv=%0b lost=%0b",
               tag, cls, sg, e, out_valid, out_int, out_invalid, out_lost, exp_int, exp_inv, exp_lost);
    end
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || out_int !== exp_int || out_invalid !== exp_inv) begin
      n_bad++;
      $display("FAIL R1 hold: got v=%0b int=%h inv=%0b exp v=0 int=%h inv=%0b",
               out_valid, out_int, out_invalid, exp_int, exp_inv);
    end
  endtask

  function automatic logic [MANT_W-2:0] pat(input int p);
    case (p)
      0: pat = '0;
      1: pat = '1;
      2: pat = (MANT_W-1)'({33{2'b10}});
      3: pat = (MANT_W-1)'(1);
      4: pat = (MANT_W-1)'(1) << 33;
      default: pat = (MANT_W-1)'(65'h1_3C5A_9E07_D2B4_F861);
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    n_vec++;
    if (out_valid !== 0 || out_int !== '0 || out_invalid !== 0 || out_lost !== 0) begin
      n_bad++;
      $display("FAIL R1 reset: got v=%0b int=%h inv=%0b lost=%0b exp all 0",
               out_valid, out_int, out_invalid, out_lost);
    end
    // R2 zero class ignores other fields
    apply(3'd0, 1'b1, 40, '1, 1'b1);
    apply(3'd0, 1'b0, -5, '0, 1'b0);
    // R8 non-numbers, both signs
    for (int c = 2; c < 8; c++) begin
      apply(3'(c), 1'b0, 3, '1, 1'b0);
      apply(3'(c), 1'b1, 3, '1, 1'b1);
    end
    // R6 boundary at exponent 31 with lone leading one
    apply(3'd1, 1'b1, 31, {1'b1, {(MANT_W-1){1'b0}}}, 1'b0);
    apply(3'd1, 1'b0, 31, {1'b1, {(MANT_W-1){1'b0}}}, 1'b0);
    // R7 / R5 extreme exponents
    apply(3'd1, 1'b0, 1000, '1, 1'b0);
    apply(3'd1, 1'b1, -1000, {1'b1, {(MANT_W-1){1'b0}}}, 1'b0);
    // R3..R7 sweep
    for (int e = -3; e <= 34; e++)
      for (int p = 0; p < 6; p++)
        for (int s = 0; s < 2; s++)
          for (int t = 0; t < 2; t++)
            apply(3'd1, 1'(s), e, {1'b1, pat(p)}, 1'(t));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule